// File: doc/BRIEF.md
# UART FIFO Mode Control Registers

This block is the byte-wide register front end of a 16550-style UART operating in FIFO mode. A processor reaches eight register slots through a 3-bit address, with separate write and read strobes. The block holds a receive FIFO and a transmit FIFO of 16 bytes each, and it accepts FIFO control writes. It reports the interrupt source and the FIFO mode in the identification readback. It also provides a scratch register and the two divisor latch bytes.

Serial shifting, baud generation and modem control sit outside the block. Handshake ports stand in for the shift registers. The receive side pushes bytes in with `rx_push`. The transmit side takes bytes out with `tx_pop` while `tx_avail` is high.

An interrupt is raised in two cases:
- the receive FIFO reaches a programmable fill level;
- the transmit FIFO has drained.

With the FIFOs enabled, the transmitter therefore interrupts once per 16 bytes rather than once per byte.

Top module: `uart_fifo_regs`

## Requirements
- R1: After reset, offset 2 reads 0x01, `irq` is low, and offsets 3 (line control) and 7 (scratch) read 0x00.
- R2: A byte written to offset 7 reads back unchanged from offset 7.
- R3: While line control (offset 3) bit 7 is 1, offsets 0 and 1 read and write the divisor low and high bytes. These accesses touch neither FIFO nor the interrupt enable register. When bit 7 is 0, offset 1 is the interrupt enable register: bit 0 enables the receive interrupt and bit 1 enables the transmit interrupt.
- R4: A write to offset 2 stores its bit 0 as FIFO enable. Offset 2 then reads with bits 7:6 = 11 if the FIFO is enabled, and 00 if it is not. A write that changes bit 0 empties both FIFOs.
- R5: With FIFO enabled, each FIFO holds 16 bytes. With FIFO disabled, each holds 1 byte. `rx_full` is high at capacity. A push into a full FIFO is dropped.
- R6: Reading offset 0 (line control bit 7 = 0) pops receive bytes in arrival order. A read of an empty receive FIFO returns 0x00.
- R7: Offset-2 write bits 7:6 select the receive trigger: 00 gives 1 byte, 01 gives 4, 10 gives 8, 11 gives 14. With FIFO disabled, the trigger is 1 byte. The receive interrupt is pending while fill >= trigger. It reads as identification bits 3:0 = 0100.
- R8: Offset-2 write bit 1 empties the receive FIFO and bit 2 empties the transmit FIFO. These bits are not stored, so a later write without them keeps the data.
- R9: The transmit interrupt flag is set in two cases: the last transmit byte is popped, or interrupt enable bit 1 goes from 0 to 1 while the transmit FIFO is empty. It is reported as bits 3:0 = 0010. It is cleared by an offset-2 read that reports it, or by a data write to offset 0.
- R10: With FIFO enabled and 16 bytes queued, no transmit interrupt occurs until the 16th byte is popped.
- R11: A pending receive interrupt is reported ahead of a pending transmit interrupt. An offset-2 read that reports the receive source leaves the transmit flag set. Bit 0 of offset 2 is 1 when nothing is pending, and `irq` is high whenever something is pending.
- R12: A receive push and a processor data read in the same cycle both take effect, and the fill is unchanged.
- R13: A data write to offset 0 while the transmit FIFO is at capacity is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (pops data / acknowledges interrupt) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| irq | output | 1 | Interrupt request, active high |
| rx_push | input | 1 | Push a received byte |
| rx_byte | input | 8 | Received byte |
| rx_full | output | 1 | Receive FIFO at capacity |
| tx_pop | input | 1 | Take the head transmit byte |
| tx_byte | output | 8 | Head transmit byte |
| tx_avail | output | 1 | Transmit FIFO not empty |

## Verification
Two events can fall in the same cycle: a byte arriving on the receive port, and a processor read of the receive data register. The bench creates this collision while the FIFO sits exactly at a trigger level of four, by raising `rx_push` and the offset-0 read strobe on the same edge. The collision is judged by three results:
- the read must return the oldest byte;
- `irq` must stay asserted, because the fill must not change;
- the following reads must deliver the remaining bytes, followed by the new byte, in order.

// File: rtl/uart_fifo_regs.sv
module uart_fifo_regs #(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  input  logic       rx_push,
  input  logic [7:0] rx_byte,
  output logic       rx_full,
  input  logic       tx_pop,
  output logic [7:0] tx_byte,
  output logic       tx_avail
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [7:0] lcr, dll, dlm, scr;
  logic [1:0] ier, trig_sel;
  logic       fifo_en, tx_flag;
  logic [7:0] rx_mem [DEPTH];
  logic [7:0] tx_mem [DEPTH];
  logic [AW-1:0] rx_wp, rx_rp, tx_wp, tx_rp;
  logic [CW-1:0] rx_cnt, tx_cnt, cap, trig;
  logic [7:0] iir;

  wire dlab     = lcr[7];
  wire wr_dat   = wr_en && addr == 3'd0 && !dlab;
  wire rd_dat   = rd_en && addr == 3'd0 && !dlab;
  wire wr_ctl   = wr_en && addr == 3'd2;
  wire rd_iir   = rd_en && addr == 3'd2;
  wire mode_chg = wr_ctl && (wdata[0] != fifo_en);
  wire rx_clr   = wr_ctl && (wdata[1] || mode_chg);
  wire tx_clr   = wr_ctl && (wdata[2] || mode_chg);

  assign cap = fifo_en ? CW'(DEPTH) : CW'(1);

  always_comb begin
    if (!fifo_en) trig = CW'(1);
    else case (trig_sel)
      2'd0:    trig = CW'(1);
      2'd1:    trig = CW'(DEPTH / 4);
      2'd2:    trig = CW'(DEPTH / 2);
      default: trig = CW'(DEPTH - 2);
    endcase
  end

  wire rx_do_push = rx_push && (rx_cnt < cap);
  wire rx_do_pop  = rd_dat && (rx_cnt != '0);
  wire tx_do_push = wr_dat && (tx_cnt < cap);
  wire tx_do_pop  = tx_pop && (tx_cnt != '0);

  always_ff @(posedge clk)
    if (rx_do_push) rx_mem[rx_wp] <= rx_byte;

  always_ff @(posedge clk)
    if (tx_do_push) tx_mem[tx_wp] <= wdata;

  always_ff @(posedge clk) begin
    if (!rst_n || rx_clr) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_do_push) rx_wp <= rx_wp + AW'(1);
      if (rx_do_pop)  rx_rp <= rx_rp + AW'(1);
      rx_cnt <= rx_cnt + CW'(rx_do_push) - CW'(rx_do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || tx_clr) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_do_push) tx_wp <= tx_wp + AW'(1);
      if (tx_do_pop)  tx_rp <= tx_rp + AW'(1);
      tx_cnt <= tx_cnt + CW'(tx_do_push) - CW'(tx_do_pop);
    end
  end

  wire rx_pend = ier[0] && (rx_cnt >= trig);
  wire tx_pend = ier[1] && tx_flag;
  wire [2:0] src_id = rx_pend ? 3'b010 : (tx_pend ? 3'b001 : 3'b000);
  assign iir = {fifo_en, fifo_en, 2'b00, src_id, !(rx_pend || tx_pend)};
  assign irq = rx_pend || tx_pend;

  wire ier_rise = wr_en && addr == 3'd1 && !dlab && wdata[1] && !ier[1] && tx_cnt == '0;
  wire tx_last  = tx_do_pop && tx_cnt == CW'(1);
  wire tx_ack   = rd_iir && src_id == 3'b001;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lcr <= '0; dll <= '0; dlm <= '0; scr <= '0;
      ier <= '0; trig_sel <= '0; fifo_en <= 1'b0; tx_flag <= 1'b0;
    end else begin
      if (wr_en) begin
        case (addr)
          3'd0: if (dlab) dll <= wdata;
          3'd1: if (dlab) dlm <= wdata; else ier <= wdata[1:0];
          3'd2: begin fifo_en <= wdata[0]; trig_sel <= wdata[7:6]; end
          3'd3: lcr <= wdata;
          3'd7: scr <= wdata;
          default: ;
        endcase
      end
      if (tx_do_push)             tx_flag <= 1'b0;
      else if (tx_last || ier_rise) tx_flag <= 1'b1;
      else if (tx_ack)            tx_flag <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      3'd0:    rdata = dlab ? dll : ((rx_cnt != '0) ? rx_mem[rx_rp] : 8'h00);
      3'd1:    rdata = dlab ? dlm : {6'b0, ier};
      3'd2:    rdata = iir;
      3'd3:    rdata = lcr;
      3'd7:    rdata = scr;
      default: rdata = 8'h00;
    endcase
  end

  assign rx_full  = rx_cnt >= cap;
  assign tx_byte  = tx_mem[tx_rp];
  assign tx_avail = tx_cnt != '0;
endmodule

// File: rtl/uart_fifo_regs_chk.sv
module uart_fifo_regs_chk #(
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    addr,
  input logic          wr_en,
  input logic          rd_en,
  input logic [7:0]    wdata,
  input logic          rx_push,
  input logic          rx_full,
  input logic          dlab,
  input logic [CW-1:0] rx_cnt,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] cap,
  input logic [7:0]    iir,
  input logic [7:0]    scr
);
  AST_RX_WITHIN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= cap); // R5
  AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && rx_push && !(rd_en && addr == 3'd0 && !dlab) && !(wr_en && addr == 3'd2))
    |=> rx_cnt == $past(rx_cnt)); // R5
  AST_MODE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd2) |=> iir[7:6] == {2{$past(wdata[0])}}); // R4
  AST_RX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd2 && wdata[1]) |=> rx_cnt == '0); // R8
  AST_SCRATCH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd7) |=> scr == $past(wdata)); // R2
  AST_DIVISOR_NO_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd0 && dlab) |=> tx_cnt == $past(tx_cnt)); // R3
endmodule

bind uart_fifo_regs uart_fifo_regs_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .wdata(wdata), .rx_push(rx_push), .rx_full(rx_full), .dlab(lcr[7]),
  .rx_cnt(rx_cnt), .tx_cnt(tx_cnt), .cap(cap), .iir(iir), .scr(scr)
);

// File: tb/uart_fifo_regs_bench.sv
module uart_fifo_regs_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0, rx_push = 1'b0, tx_pop = 1'b0;
  logic [7:0] wdata = '0, rx_byte = '0;
  logic [7:0] rdata, tx_byte;
  logic irq, rx_full, tx_avail;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  uart_fifo_regs u_uart_fifo_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .irq(irq), .rx_push(rx_push),
    .rx_byte(rx_byte), .rx_full(rx_full), .tx_pop(tx_pop),
    .tx_byte(tx_byte), .tx_avail(tx_avail)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string req);
    logic [7:0] d;
    bus_rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic rx_in(input logic [7:0] b);
    @(negedge clk); rx_byte = b; rx_push = 1'b1;
    @(negedge clk); rx_push = 1'b0;
  endtask

  task automatic tx_out(output logic [7:0] b);
    @(negedge clk); b = tx_byte; tx_pop = 1'b1;
    @(negedge clk); tx_pop = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 irq", {7'b0, irq}, 8'h00);
    rd_chk(3'd2, 8'h01, "R1 iir");
    rd_chk(3'd3, 8'h00, "R1 lcr");
    rd_chk(3'd7, 8'h00, "R1 scratch");
  endtask

  task automatic t_scratch;
    bus_wr(3'd7, 8'hAA); rd_chk(3'd7, 8'hAA, "R2 scratch AA");
    bus_wr(3'd7, 8'h55); rd_chk(3'd7, 8'h55, "R2 scratch 55");
  endtask

  task automatic t_dlab;
    bus_wr(3'd3, 8'h80);
    bus_wr(3'd0, 8'h30);
    bus_wr(3'd1, 8'h12);
    rd_chk(3'd0, 8'h30, "R3 divisor low");
    rd_chk(3'd1, 8'h12, "R3 divisor high");
    chk("R3 no tx push", {7'b0, tx_avail}, 8'h00);
    bus_wr(3'd3, 8'h03);
    rd_chk(3'd1, 8'h00, "R3 ier untouched");
    rd_chk(3'd3, 8'h03, "R3 lcr");
    rd_chk(3'd0, 8'h00, "R6 empty read");
  endtask

  task automatic t_fifo_en;
    bus_wr(3'd2, 8'h01);
    rd_chk(3'd2, 8'hC1, "R4 iir fifo on");
  endtask

  task automatic t_depth;
    bus_wr(3'd2, 8'hC1);
    for (int i = 0; i < 17; i++) rx_in(8'(8'h10 + i));
    chk("R5 rx_full", {7'b0, rx_full}, 8'h01);
    for (int i = 0; i < 16; i++) rd_chk(3'd0, 8'(8'h10 + i), "R6 order");
    rd_chk(3'd0, 8'h00, "R5 17th dropped");
  endtask

  task automatic t_trigger;
    int lv [4] = '{1, 4, 8, 14};
    for (int l = 0; l < 4; l++) begin
      bus_wr(3'd2, {2'(l), 6'b000011});
      bus_wr(3'd1, 8'h01);
      for (int i = 0; i < lv[l] - 1; i++) rx_in(8'(i));
      chk("R7 below trigger", {7'b0, irq}, 8'h00);
      rx_in(8'hEE);
      chk("R7 at trigger", {7'b0, irq}, 8'h01);
      rd_chk(3'd2, 8'hC4, "R7 iir rx");
      rd_chk(3'd0, (lv[l] == 1) ? 8'hEE : 8'h00, "R7 pop");
      chk("R7 drop below", {7'b0, irq}, 8'h00);
    end
    bus_wr(3'd1, 8'h00);
  endtask

  task automatic t_clear;
    bus_wr(3'd2, 8'h03);
    rx_in(8'hA1); rx_in(8'hA2); rx_in(8'hA3);
    bus_wr(3'd0, 8'h51); bus_wr(3'd0, 8'h52);
    bus_wr(3'd2, 8'h01);
    rd_chk(3'd0, 8'hA1, "R8 no clear bits keeps rx");
    bus_wr(3'd2, 8'h03);
    rd_chk(3'd0, 8'h00, "R8 rx cleared");
    chk("R8 tx kept", {7'b0, tx_avail}, 8'h01);
    bus_wr(3'd2, 8'h05);
    chk("R8 tx cleared", {7'b0, tx_avail}, 8'h00);
  endtask

  task automatic t_tx_int;
    logic [7:0] b;
    bus_wr(3'd1, 8'h02);
    chk("R9 enable rise", {7'b0, irq}, 8'h01);
    rd_chk(3'd2, 8'hC2, "R9 iir tx");
    chk("R9 ack by iir", {7'b0, irq}, 8'h00);
    rd_chk(3'd2, 8'hC1, "R9 none pending");
    for (int i = 0; i < 17; i++) bus_wr(3'd0, 8'(8'h60 + i));
    for (int i = 0; i < 15; i++) begin
      tx_out(b);
      chk("R10 tx order", b, 8'(8'h60 + i));
    end
    chk("R10 no early irq", {7'b0, irq}, 8'h00);
    tx_out(b);
    chk("R10 16th byte", b, 8'h6F);
    chk("R10 irq on drain", {7'b0, irq}, 8'h01);
    chk("R13 17th dropped", {7'b0, tx_avail}, 8'h00);
    bus_wr(3'd0, 8'h77);
    chk("R9 cleared by write", {7'b0, irq}, 8'h00);
    tx_out(b);
    chk("R9 byte", b, 8'h77);
    chk("R9 set again", {7'b0, irq}, 8'h01);
    rd_chk(3'd2, 8'hC2, "R9 iir tx again");
    chk("R9 ack", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_priority;
    logic [7:0] b;
    bus_wr(3'd1, 8'h03);
    bus_wr(3'd0, 8'h33);
    tx_out(b);
    rx_in(8'h44);
    rd_chk(3'd2, 8'hC4, "R11 rx first");
    rd_chk(3'd2, 8'hC4, "R11 tx not acked");
    rd_chk(3'd0, 8'h44, "R11 pop rx");
    rd_chk(3'd2, 8'hC2, "R11 tx next");
    rd_chk(3'd2, 8'hC1, "R11 none");
  endtask

  task automatic t_same_cycle;
    logic [7:0] d;
    bus_wr(3'd1, 8'h01);
    bus_wr(3'd2, 8'h43);
    for (int i = 1; i <= 4; i++) rx_in(8'(8'h80 + i));
    chk("R12 at trigger", {7'b0, irq}, 8'h01);
    @(negedge clk); addr = 3'd0; rd_en = 1'b1; rx_byte = 8'h99; rx_push = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0; rx_push = 1'b0;
    chk("R12 read oldest", d, 8'h81);
    chk("R12 fill held", {7'b0, irq}, 8'h01);
    rd_chk(3'd0, 8'h82, "R12 order");
    rd_chk(3'd0, 8'h83, "R12 order");
    rd_chk(3'd0, 8'h84, "R12 order");
    rd_chk(3'd0, 8'h99, "R12 pushed byte");
    rd_chk(3'd0, 8'h00, "R12 empty");
  endtask

  task automatic t_nonfifo;
    logic [7:0] b;
    bus_wr(3'd2, 8'hC0);
    rd_chk(3'd2, 8'h01, "R4 iir fifo off");
    rx_in(8'h21);
    chk("R5 cap one", {7'b0, rx_full}, 8'h01);
    chk("R7 trigger one", {7'b0, irq}, 8'h01);
    rd_chk(3'd2, 8'h04, "R7 iir rx no fifo");
    rx_in(8'h22);
    rd_chk(3'd0, 8'h21, "R5 first kept");
    rd_chk(3'd0, 8'h00, "R5 second dropped");
    bus_wr(3'd1, 8'h00);
    bus_wr(3'd0, 8'h31); bus_wr(3'd0, 8'h32);
    tx_out(b);
    chk("R13 tx head", b, 8'h31);
    chk("R13 tx cap one", {7'b0, tx_avail}, 8'h00);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_scratch();
    t_dlab();
    t_fifo_en();
    t_depth();
    t_trigger();
    t_clear();
    t_tx_int();
    t_priority();
    t_same_cycle();
    t_nonfifo();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule